// File: doc/BRIEF.md
# Ethernet Receive Frame Type Classifier

This block watches the receive-side client stream of an Ethernet MAC, one wide beat per clock, and reports what kind of frame each packet is. It reads the header only from the beat that opens a packet, where the first frame byte sits in the top byte lane. It recognises one or two VLAN tags, MAC control frames, and, among control frames, PAUSE and priority flow control requests. It does not check frames for errors and takes no action on pause requests.

The result is a 40-bit status word. Its upper bits carry the type flags and every other bit reads zero. The word comes with a one-cycle valid strobe in the cycle that closes the packet. Downstream logic can latch the word on that strobe next to the packet's error flags and use it to steer or count traffic.

Top module: `eth_rx_frame_status`

## Requirements
- R1: After reset, `status_valid` is low and `status_word` is zero until a packet closes.
- R2: `status_valid` is high for exactly one cycle per packet, the cycle that has `rx_valid`, `rx_eop` and a packet opened by a valid `rx_sop` beat. A valid end beat with no packet open produces no strobe.
- R3: Frame byte k sits in `rx_data[DATA_W-1-8k -: 8]` on the opening beat. The first type or tag field is bytes 12 and 13, most significant byte first. Values at other offsets do not set a flag.
- R4: An outer field of 0x8100 or 0x88A8 that is not followed at bytes 16 and 17 by 0x8100 marks a single-tagged frame: bit 33 is set and bit 32 is clear.
- R5: An outer field of 0x8100 or 0x88A8 followed by 0x8100 marks a double-tagged frame: bit 32 is set and bit 33 is clear.
- R6: The type field is read after all recognised tags, at byte 12, 16 or 20. A value of 0x8808 there sets bit 34 (control frame).
- R7: In a control frame, an opcode of 0x0001 in the two bytes after the type field sets bit 35 (PAUSE).
- R8: In a control frame, an opcode of 0x0101 sets bit 39 (priority flow control). Bits 39 and 35 are never both set.
- R9: Bits 38:36 and 31:0 are always zero. The whole word is zero whenever `status_valid` is low.
- R10: A packet whose opening and closing beat are the same beat is classified from that beat.
- R11: Beats with `rx_valid` low are ignored, whatever `rx_sop`, `rx_eop` and `rx_data` carry. Data on beats after the opening beat does not change the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Beat qualifier |
| rx_sop | input | 1 | Beat opens a packet |
| rx_eop | input | 1 | Beat closes a packet |
| rx_data | input | DATA_W | Beat data, first byte in the top lane |
| status_valid | output | 1 | One-cycle strobe with the frame status |
| status_word | output | 40 | Frame type flags: 39 PFC, 35 PAUSE, 34 control, 33 VLAN, 32 double VLAN |

## Verification
Header capture and status release can fall in the same cycle: a one-beat packet opens and closes at once, so the parse must go straight to the output without the holding register. The bench provokes this with a one-beat PAUSE frame placed right after a multi-beat packet. It also sends a one-beat packet right after the end beat of another packet, so that a strobe falls in each of two adjacent cycles. Each strobe is popped from the scoreboard queue and its word is compared in full, so a word left over from the previous frame or a missing strobe shows up as a mismatch or as queue debris.

// File: rtl/eth_rxs_pkg.sv
package eth_rxs_pkg;
  localparam int STAT_W  = 40;
  localparam int B_PFC   = 39;
  localparam int B_PAUSE = 35;
  localparam int B_CTRL  = 34;
  localparam int B_VLAN  = 33;
  localparam int B_QINQ  = 32;

  localparam logic [15:0] TPID_C     = 16'h8100;
  localparam logic [15:0] TPID_S     = 16'h88A8;
  localparam logic [15:0] ETYPE_MACC = 16'h8808;
  localparam logic [15:0] OPC_PAUSE  = 16'h0001;
  localparam logic [15:0] OPC_PFC    = 16'h0101;

  // Header bytes the parser needs: up to a type plus opcode after two tags.
  localparam int HDR_BYTES = 24;
  localparam int HDR_W     = HDR_BYTES * 8;

  typedef struct packed {
    logic pfc;
    logic pause;
    logic ctrl;
    logic vlan;
    logic qinq;
  } hdr_flags_t;

  function automatic logic [STAT_W-1:0] pack_status(input hdr_flags_t f);
    logic [STAT_W-1:0] w;
    w = '0;
    w[B_PFC]   = f.pfc;
    w[B_PAUSE] = f.pause;
    w[B_CTRL]  = f.ctrl;
    w[B_VLAN]  = f.vlan;
    w[B_QINQ]  = f.qinq;
    return w;
  endfunction
endpackage

// File: rtl/eth_rxs_hdr_parse.sv
module eth_rxs_hdr_parse
  import eth_rxs_pkg::*;
(
  input  logic [HDR_W-1:0] hdr,
  output hdr_flags_t       flags
);
  // Field of two bytes starting at byte index idx, first byte in the top lane.
  function automatic logic [15:0] fld16(input logic [HDR_W-1:0] h, input int idx);
    return h[HDR_W-1-8*idx -: 16];
  endfunction

  logic [15:0] outer_f, mid_f, in_f;
  logic        outer_tag, inner_tag;
  logic [15:0] type_f, opc_f;
  logic        is_ctrl;

  assign outer_f   = fld16(hdr, 12);
  assign mid_f     = fld16(hdr, 16);
  assign in_f      = fld16(hdr, 20);
  assign outer_tag = (outer_f == TPID_C) || (outer_f == TPID_S);
  assign inner_tag = outer_tag && (mid_f == TPID_C);

  always_comb begin
    if (inner_tag) begin
      type_f = in_f;
      opc_f  = fld16(hdr, 22);
    end else if (outer_tag) begin
      type_f = mid_f;
      opc_f  = fld16(hdr, 18);
    end else begin
      type_f = outer_f;
      opc_f  = fld16(hdr, 14);
    end
  end

  assign is_ctrl     = (type_f == ETYPE_MACC);
  assign flags.ctrl  = is_ctrl;
  assign flags.pause = is_ctrl && (opc_f == OPC_PAUSE);
  assign flags.pfc   = is_ctrl && (opc_f == OPC_PFC);
  assign flags.vlan  = outer_tag && !inner_tag;
  assign flags.qinq  = inner_tag;
endmodule

// File: rtl/eth_rxs_frame_track.sv
module eth_rxs_frame_track
  import eth_rxs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat_ok,
  input  logic       sop,
  input  logic       eop,
  input  hdr_flags_t flags_now,
  output logic       emit,
  output hdr_flags_t flags_out,
  output logic       in_frame
);
  hdr_flags_t held;
  logic       open_beat, close_beat;

  assign open_beat  = beat_ok && sop;
  assign close_beat = beat_ok && eop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      held     <= '0;
    end else if (open_beat && !eop) begin
      in_frame <= 1'b1;
      held     <= flags_now;
    end else if (close_beat) begin
      in_frame <= 1'b0;
    end
  end

  assign emit      = close_beat && (sop || in_frame);
  assign flags_out = sop ? flags_now : held;

  // R2: once a packet has reported, no packet is left open
  p_close_after_emit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> !in_frame);
  // R7: a held PAUSE flag always comes with the control flag
  p_held_pause_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame |-> (!held.pause || held.ctrl));
  // R11: an idle beat neither opens nor closes a packet
  p_idle_keeps_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_ok |=> $stable(in_frame));
endmodule

// File: rtl/eth_rx_frame_status.sv
module eth_rx_frame_status
  import eth_rxs_pkg::*;
#(
  parameter int DATA_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic [DATA_W-1:0] rx_data,
  output logic              status_valid,
  output logic [STAT_W-1:0] status_word
);
  localparam int TAIL_W = DATA_W - HDR_W;

  hdr_flags_t parsed, chosen;
  logic       emit, in_frame;

  generate
    if (TAIL_W > 0) begin : g_tail
      logic unused_tail;
      assign unused_tail = ^rx_data[TAIL_W-1:0];
    end
  endgenerate

  eth_rxs_hdr_parse u_parse (
    .hdr   (rx_data[DATA_W-1 -: HDR_W]),
    .flags (parsed)
  );

  eth_rxs_frame_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_ok   (rx_valid),
    .sop       (rx_sop),
    .eop       (rx_eop),
    .flags_now (parsed),
    .emit      (emit),
    .flags_out (chosen),
    .in_frame  (in_frame)
  );

  assign status_valid = emit;
  assign status_word  = emit ? pack_status(chosen) : '0;

  // R5: single and double tag flags are exclusive
  p_tag_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> ($countones(status_word[B_VLAN:B_QINQ]) <= 1));
  // R8: PFC and PAUSE never both, and PFC implies control
  p_pfc_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> !(status_word[B_PFC] && status_word[B_PAUSE]) &&
                     (!status_word[B_PFC] || status_word[B_CTRL]));
  // R11: no strobe on a beat without valid
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> !status_valid);
  // R2: a strobe needs a packet opened now or earlier
  p_strobe_needs_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> (rx_sop || in_frame));
endmodule

// File: tb/tb_eth_rx_frame_status.sv
module tb_eth_rx_frame_status;
  localparam int DW = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          status_valid;
  logic [39:0]   status_word;

  int tests = 0, fails = 0;
  logic [39:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  eth_rx_frame_status #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .rx_data(rx_data),
    .status_valid(status_valid), .status_word(status_word)
  );

  function automatic logic [39:0] xw(input bit pfc, pause, ctrl, vl, qq);
    return {pfc, 3'b000, pause, ctrl, vl, qq, 32'h0};
  endfunction

  function automatic logic [DW-1:0] mkhdr(input logic [15:0] w12, w14, w16, w18, w20, w22);
    logic [DW-1:0] d;
    d = '0;
    d[511:464] = 48'h01_80_C2_00_00_01;
    d[463:416] = 48'h00_11_22_33_44_55;
    d[415:400] = w12; d[399:384] = w14; d[383:368] = w16;
    d[367:352] = w18; d[351:336] = w20; d[335:320] = w22;
    d[15:0]    = 16'hA5A5;
    return d;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [39:0] act, exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n && status_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected status strobe", status_word, 40'h0);
      end else begin
        logic [39:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(status_word === e, t, status_word, e);
      end
    end else if (rst_n) begin
      if (status_word !== 40'h0) chk(1'b0, "R9 word nonzero while idle", status_word, 40'h0);
    end
  end

  // driver: nbeats beats, gap idle cycles between beats carrying junk
  task automatic send(input logic [DW-1:0] hdr, input int nbeats, input int gap,
                      input logic [39:0] exp, input string t);
    exp_q.push_back(exp);
    tag_q.push_back(t);
    for (int b = 0; b < nbeats; b++) begin
      if (b > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(posedge clk); #1;
          rx_valid = 1'b0; rx_sop = 1'b1; rx_eop = 1'b1;
          rx_data = mkhdr(16'h8808, 16'h0101, 16'h0, 16'h0, 16'h0, 16'h0);
        end
      end
      @(posedge clk); #1;
      rx_valid = 1'b1;
      rx_sop   = (b == 0);
      rx_eop   = (b == nbeats - 1);
      rx_data  = (b == 0) ? hdr : mkhdr(16'h8808, 16'h0001, 16'h0, 16'h0, 16'h0, 16'h0);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_data = '0;
    end
  endtask

  initial begin
    #(20 * 200000);
    chk(1'b0, "watchdog expired", 40'h0, 40'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(status_valid === 1'b0 && status_word === 40'h0, "R1 reset state",
        status_word, 40'h0);

    send(mkhdr(16'h0800, 16'h4500, 0, 0, 0, 0), 3, 0, xw(0,0,0,0,0), "R3 untagged IPv4");
    send(mkhdr(16'h8100, 16'h0005, 16'h0800, 0, 0, 0), 2, 1, xw(0,0,0,1,0), "R4 single 8100");
    send(mkhdr(16'h88A8, 16'h0007, 16'h0800, 0, 0, 0), 2, 0, xw(0,0,0,1,0), "R4 single 88A8");
    send(mkhdr(16'h88A8, 16'h0007, 16'h8100, 16'h0009, 16'h0800, 0), 2, 0, xw(0,0,0,0,1), "R5 88A8+8100");
    send(mkhdr(16'h8100, 16'h0001, 16'h8100, 16'h0002, 16'h0800, 0), 4, 2, xw(0,0,0,0,1), "R5 8100+8100");
    send(mkhdr(16'h8808, 16'h0001, 0, 0, 0, 0), 2, 0, xw(0,1,1,0,0), "R7 pause");
    send(mkhdr(16'h8808, 16'h0101, 0, 0, 0, 0), 2, 0, xw(1,0,1,0,0), "R8 pfc");
    send(mkhdr(16'h8808, 16'h0002, 0, 0, 0, 0), 2, 0, xw(0,0,1,0,0), "R6 control other opcode");
    send(mkhdr(16'h8100, 16'h0003, 16'h8808, 16'h0001, 0, 0), 2, 0, xw(0,1,1,1,0), "R6 tagged pause");
    send(mkhdr(16'h88A8, 16'h0000, 16'h8100, 16'h0000, 16'h8808, 16'h0101), 2, 0, xw(1,0,1,0,1), "R6 double tagged pfc");
    // back-to-back: one-beat frame directly after a multi-beat end
    send(mkhdr(16'h8808, 16'h0001, 0, 0, 0, 0), 1, 0, xw(0,1,1,0,0), "R10 one-beat pause");
    send(mkhdr(16'h0800, 16'h8808, 16'h0001, 0, 0, 0), 1, 0, xw(0,0,0,0,0), "R3 type at wrong offset");
    send(mkhdr(16'h0806, 0, 0, 0, 0, 0), 5, 3, xw(0,0,0,0,0), "R11 later beats ignored");
    idle(2);

    // stray end beat with no packet open
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_sop = 1'b0; rx_eop = 1'b1;
    rx_data = mkhdr(16'h8808, 16'h0001, 0, 0, 0, 0);
    @(negedge clk);
    chk(status_valid === 1'b0, "R2 stray end beat", {39'h0, status_valid}, 40'h0);
    idle(1);

    // opening beat without valid, then a real untagged one-beat frame
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_sop = 1'b1; rx_eop = 1'b0;
    rx_data = mkhdr(16'h8808, 16'h0101, 0, 0, 0, 0);
    @(negedge clk);
    chk(status_valid === 1'b0, "R11 invalid opening beat", {39'h0, status_valid}, 40'h0);
    send(mkhdr(16'h0800, 0, 0, 0, 0, 0), 1, 0, xw(0,0,0,0,0), "R11 frame after invalid sop");
    idle(3);

    chk(exp_q.size() == 0, "R2 missing status strobes", 40'(exp_q.size()), 40'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule